// File: doc/BRIEF.md
# Program Counter and Next-Fetch Address Sequencer

This block owns the program counter of a single-cycle core that runs a small subset of a 32-bit load/store instruction set with no branch delay slot. Each clock edge it loads the counter with one of four candidates: the sequential address (counter plus four), a conditional branch target relative to the sequential address, a pseudo-direct jump target built from the instruction index field, or a full 32-bit value read from the register file. Decoding is done elsewhere: the block receives one strobe per control-flow class together with the ALU zero flag, which qualifies a conditional branch.

Alongside the counter it exposes the sequential address for the link write of a jump-and-link, and a word index for a 256-word instruction ROM taken from the byte-addressed counter. Reset is synchronous and returns the counter to address zero, so the first fetch after reset is word 0, the next word 1, and so on.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_q` becomes 0x00000000 after that edge, whatever the other inputs are.
- R2: With no strobe active, or with `br_en` high and `alu_zero` low, or with `alu_zero` high and `br_en` low, `pc_q` after the edge equals the previous `pc_q` plus 4, modulo 2^32.
- R3: `link_addr` always equals `pc_q` plus 4 (modulo 2^32), the value a jump-and-link writes to register 31.
- R4: `rom_addr` always equals bits [9:2] of `pc_q`, the word index into a 256-entry ROM.
- R5: With `jmp_en` or `jal_en` high (and `jr_en` low), `pc_q` after the edge equals {bits [31:28] of `pc_q`+4, `instr_field[25:0]`, 2'b00}.
- R6: With `jr_en` high, `pc_q` after the edge equals `jr_value` sampled at that edge.
- R7: With `br_en` and `alu_zero` both high (and `jr_en`, `jmp_en`, `jal_en` low), `pc_q` after the edge equals `pc_q`+4 plus the sign-extended `instr_field[15:0]` shifted left by two.
- R8: When several strobes are high, `jr_en` wins over `jmp_en`/`jal_en`, which win over a taken branch, which wins over the sequential address.
- R9: A redirect takes effect on the very next counter value: the fetch following a taken branch or jump is the target, with no intervening sequential word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_field | input | 26 | Low 26 bits of the current instruction: jump index, low 16 bits branch offset |
| jr_value | input | 32 | Register value used by jump-register |
| alu_zero | input | 1 | ALU zero flag qualifying a branch |
| br_en | input | 1 | Current instruction is a conditional branch-on-equal |
| jmp_en | input | 1 | Current instruction is a plain jump |
| jal_en | input | 1 | Current instruction is a jump-and-link |
| jr_en | input | 1 | Current instruction is a jump-register |
| pc_q | output | 32 | Program counter (byte address of current fetch) |
| link_addr | output | 32 | Counter plus four, for the link write |
| rom_addr | output | 8 | Word index into the instruction ROM |

## Verification
The counter is walked through runs of sequential steps, forward and backward taken branches, branches whose zero flag or strobe is missing, plain jumps and jump-and-links inside a non-zero upper address region, and jump-register loads including an address near the top of the space that makes the sequential increment wrap. Jumps issued from a non-zero region tell apart a target built from the sequential address's upper bits and one built from zeros, while the missing-qualifier branches tell apart a correct AND of strobe and flag from either input alone. Combinations of two or more strobes in one cycle separate the priority order, and a reset in mid-run shows that reset overrides an active redirect. A counter above 0x3FF confirms that the ROM index drops the upper bits.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    typedef enum logic [1:0] {
        NPC_SEQ    = 2'd0,
        NPC_BRANCH = 2'd1,
        NPC_JUMP   = 2'd2,
        NPC_REG    = 2'd3
    } npc_src_e;

    localparam int unsigned IDX_W = 26;
    localparam int unsigned OFS_W = 16;

endpackage

// File: rtl/pc_step_adder.sv
module pc_step_adder #(
    parameter int unsigned PC_W      = 32,
    parameter int unsigned STEP_LOG2 = 2
) (
    input  logic [PC_W-1:0]              pc_q,
    input  logic [pc_seq_pkg::OFS_W-1:0] offset,
    output logic [PC_W-1:0]              plus_step,
    output logic [PC_W-1:0]              br_target
);
    localparam int unsigned EXT_W = PC_W - pc_seq_pkg::OFS_W - STEP_LOG2;

    logic [PC_W-1:0] ofs_ext;

    always_comb begin
        plus_step = pc_q + PC_W'(1 << STEP_LOG2);
        ofs_ext   = {{EXT_W{offset[pc_seq_pkg::OFS_W-1]}}, offset, {STEP_LOG2{1'b0}}};
        br_target = plus_step + ofs_ext;
    end
endmodule

// File: rtl/pc_jump_former.sv
module pc_jump_former #(
    parameter int unsigned PC_W      = 32,
    parameter int unsigned STEP_LOG2 = 2
) (
    input  logic [PC_W-1:0]              plus_step,
    input  logic [pc_seq_pkg::IDX_W-1:0] index,
    output logic [PC_W-1:0]              jmp_target
);
    localparam int unsigned REGION_LO = pc_seq_pkg::IDX_W + STEP_LOG2;

    always_comb begin
        jmp_target = {plus_step[PC_W-1:REGION_LO], index, {STEP_LOG2{1'b0}}};
    end
endmodule

// File: rtl/pc_src_arbiter.sv
module pc_src_arbiter (
    input  logic                  alu_zero,
    input  logic                  br_en,
    input  logic                  jmp_en,
    input  logic                  jal_en,
    input  logic                  jr_en,
    output pc_seq_pkg::npc_src_e  src
);
    import pc_seq_pkg::*;

    always_comb begin
        if (jr_en)                  src = NPC_REG;
        else if (jmp_en || jal_en)  src = NPC_JUMP;
        else if (br_en && alu_zero) src = NPC_BRANCH;
        else                        src = NPC_SEQ;
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
    parameter int unsigned PC_W      = 32,
    parameter int unsigned ROM_AW    = 8,
    parameter int unsigned STEP_LOG2 = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [25:0]           instr_field,
    input  logic [PC_W-1:0]       jr_value,
    input  logic                  alu_zero,
    input  logic                  br_en,
    input  logic                  jmp_en,
    input  logic                  jal_en,
    input  logic                  jr_en,
    output logic [PC_W-1:0]       pc_q,
    output logic [PC_W-1:0]       link_addr,
    output logic [ROM_AW-1:0]     rom_addr
);
    import pc_seq_pkg::*;

    localparam int unsigned ROM_LO = STEP_LOG2;
    localparam int unsigned ROM_HI = STEP_LOG2 + ROM_AW - 1;
    localparam int unsigned EXT_W  = PC_W - OFS_W - STEP_LOG2;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } seq_state_t;

    seq_state_t state_d, state_q;
    logic [PC_W-1:0] plus_step, br_target, jmp_target;
    npc_src_e        src;

    pc_step_adder #(.PC_W(PC_W), .STEP_LOG2(STEP_LOG2)) u_adder (
        .pc_q      (state_q.pc),
        .offset    (instr_field[OFS_W-1:0]),
        .plus_step (plus_step),
        .br_target (br_target)
    );

    pc_jump_former #(.PC_W(PC_W), .STEP_LOG2(STEP_LOG2)) u_jump (
        .plus_step  (plus_step),
        .index      (instr_field),
        .jmp_target (jmp_target)
    );

    pc_src_arbiter u_arb (
        .alu_zero (alu_zero),
        .br_en    (br_en),
        .jmp_en   (jmp_en),
        .jal_en   (jal_en),
        .jr_en    (jr_en),
        .src      (src)
    );

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.pc = '0;
        end else begin
            unique case (src)
                NPC_REG:    state_d.pc = jr_value;
                NPC_JUMP:   state_d.pc = jmp_target;
                NPC_BRANCH: state_d.pc = br_target;
                default:    state_d.pc = plus_step;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign pc_q      = state_q.pc;
    assign link_addr = plus_step;
    assign rom_addr  = state_q.pc[ROM_HI:ROM_LO];

    // R1: reset overrides every strobe
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (pc_q == '0));

    // R2: no redirect means one word forward
    a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
        (!jr_en && !jmp_en && !jal_en && !(br_en && alu_zero))
        |=> (pc_q == $past(pc_q) + PC_W'(1 << STEP_LOG2)));

    // R3: link value tracks the counter
    a_r3_link_value: assert property (@(posedge clk) disable iff (rst)
        link_addr == pc_q + PC_W'(1 << STEP_LOG2));

    // R5: jump keeps the index field in the low bits
    a_r5_jump_index: assert property (@(posedge clk) disable iff (rst)
        (!jr_en && (jmp_en || jal_en))
        |=> (pc_q[IDX_W+STEP_LOG2-1:0] == {$past(instr_field), {STEP_LOG2{1'b0}}}));

    // R6 / R8: register jump wins over all other strobes
    a_r6_reg_jump: assert property (@(posedge clk) disable iff (rst)
        jr_en |=> (pc_q == $past(jr_value)));

    // R7: taken branch lands at sequential address plus scaled offset
    a_r7_branch_taken: assert property (@(posedge clk) disable iff (rst)
        (br_en && alu_zero && !jr_en && !jmp_en && !jal_en)
        |=> (pc_q == $past(pc_q) + PC_W'(1 << STEP_LOG2)
              + {{EXT_W{$past(instr_field[OFS_W-1])}},
                 $past(instr_field[OFS_W-1:0]), {STEP_LOG2{1'b0}}}));
endmodule

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;
    logic        clk = 1'b0;
    logic        rst;
    logic [25:0] instr_field;
    logic [31:0] jr_value;
    logic        alu_zero, br_en, jmp_en, jal_en, jr_en;
    logic [31:0] pc_q, link_addr;
    logic [7:0]  rom_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] model_pc;

    always #2 clk = ~clk;

    pc_sequencer dut (
        .clk(clk), .rst(rst), .instr_field(instr_field), .jr_value(jr_value),
        .alu_zero(alu_zero), .br_en(br_en), .jmp_en(jmp_en), .jal_en(jal_en),
        .jr_en(jr_en), .pc_q(pc_q), .link_addr(link_addr), .rom_addr(rom_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops one expected counter value per edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, pc_q, e);
        end
    end

    // driver: applies one instruction's strobes, checks the combinational
    // outputs, and queues the counter value expected after the edge
    task automatic step(input logic [25:0] fld, input logic [31:0] jrv,
                        input logic z, input logic b, input logic j,
                        input logic l, input logic r, input string tag);
        logic [31:0] p4, nxt;
        instr_field = fld; jr_value = jrv; alu_zero = z;
        br_en = b; jmp_en = j; jal_en = l; jr_en = r;
        #1;
        p4 = model_pc + 32'd4;
        check("R3 link", link_addr, p4);
        check("R4 rom index", {24'd0, rom_addr}, {24'd0, model_pc[9:2]});
        if (r)              nxt = jrv;
        else if (j || l)    nxt = {p4[31:28], fld, 2'b00};
        else if (b && z)    nxt = p4 + {{14{fld[15]}}, fld[15:0], 2'b00};
        else                nxt = p4;
        exp_q.push_back(nxt);
        tag_q.push_back(tag);
        model_pc = nxt;
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; instr_field = '0; jr_value = '0;
        alu_zero = 0; br_en = 0; jmp_en = 0; jal_en = 0; jr_en = 1;
        repeat (3) @(negedge clk);
        check("R1 reset pc", pc_q, 32'h0);
        check("R1 reset rom", {24'd0, rom_addr}, 32'h0);
        rst = 1'b0; jr_en = 0;
        model_pc = 32'h0;

        // R2 / R9: sequential fetch 0,4,8,...
        step(26'h0, 32'h0, 0, 0, 0, 0, 0, "R2 seq 0->4");
        step(26'h0, 32'h0, 0, 0, 0, 0, 0, "R2 seq 4->8");
        step(26'h0, 32'h0, 1, 0, 0, 0, 0, "R2 zero without branch");
        step(26'h0010, 32'h0, 0, 1, 0, 0, 0, "R2 branch not taken");
        // R7: forward then backward taken branches
        step(26'h0010, 32'h0, 1, 1, 0, 0, 0, "R7 branch forward");
        step(26'h0FFFD, 32'h0, 1, 1, 0, 0, 0, "R7 branch backward");
        // R6: register jump into upper region
        step(26'h0, 32'h3000_0100, 0, 0, 0, 0, 1, "R6 jr to region 3");
        // R5: jump and jal keep upper nibble of pc+4
        step(26'h0000_040, 32'h0, 0, 0, 1, 0, 0, "R5 jump in region 3");
        step(26'h3FF_FFFF, 32'h0, 0, 0, 0, 1, 0, "R5 jal max index");
        step(26'h0, 32'h0, 0, 0, 0, 0, 0, "R2 seq crosses region");
        // R4: counter above 0x3FF, index keeps only bits 9:2
        step(26'h0, 32'h0000_0404, 0, 0, 0, 0, 1, "R6 jr to 0x404");
        step(26'h0, 32'h0, 0, 0, 0, 0, 0, "R2 seq after jr");
        // R8: priority combinations
        step(26'h0000_080, 32'h0000_0200, 1, 1, 1, 1, 1, "R8 all strobes jr wins");
        step(26'h0000_080, 32'h0000_0200, 1, 1, 1, 0, 0, "R8 jump beats branch");
        step(26'h0000_004, 32'h0000_0200, 1, 1, 0, 1, 0, "R8 jal beats branch");
        step(26'h0000_004, 32'hDEAD_BEEC, 1, 1, 0, 0, 0, "R8 branch ignores jr value");
        // R2: wrap at top of the address space
        step(26'h0, 32'hFFFF_FFFC, 0, 0, 0, 0, 1, "R6 jr to top");
        step(26'h0, 32'h0, 0, 0, 0, 0, 0, "R2 seq wraps to 0");
        step(26'h0, 32'h0, 0, 0, 0, 0, 0, "R9 seq after wrap");

        // R1: reset in mid-run beats an active jump
        instr_field = 26'h123; jmp_en = 1; rst = 1;
        exp_q.push_back(32'h0); tag_q.push_back("R1 reset over jump");
        @(negedge clk);
        rst = 0; jmp_en = 0; model_pc = 32'h0;
        step(26'h0, 32'h0, 0, 0, 0, 0, 0, "R2 seq after reset");
        @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule